// File: doc/BRIEF.md
# Interrupt Steering Controller

This block collects up to 32 interrupt source lines, samples them every clock into a raw register, and gates them with a per-source enable. A per-source route bit then sends each enabled, active source to one of two processor inputs: the normal interrupt (`irq_o`) or the fast interrupt (`fiq_o`). It does no prioritisation and no vectoring. Software reads the raw sources and the two routed sets, and finds the source it has to service from those.

Software reaches the block over a simple word register bus. A request is a select strobe, a write flag, a byte address, write data, and combinational read data. The enable, route and control registers can be written. The raw register and the two routed views are read-only. The routing path has no registers, so a change in state shows on the outputs in the same cycle it takes effect.

Top module: `irq_steer_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the enable, route and control registers and the raw register. After reset every read returns zero and both outputs are low.
- R2: The raw register at offset 0x20 holds the value of `src_i` sampled at the previous rising clock edge.
- R3: A write to offset 0x20 has no effect. The next read of 0x20 still returns the sampled sources.
- R4: A read of offset 0x00 returns raw AND enable AND NOT route, which is the set of sources routed to the normal interrupt.
- R5: A read of offset 0x10 returns raw AND enable AND route, which is the set of sources routed to the fast interrupt.
- R6: `irq_o` is high exactly when the value readable at offset 0x00 is nonzero.
- R7: `fiq_o` is high exactly when the value readable at offset 0x10 is nonzero.
- R8: The enable register (offset 0x04) and the route register (offset 0x08) take all 32 bits of a write. A route bit of 1 selects the fast interrupt. Each register reads back its written value from the cycle after the write.
- R9: The control register (offset 0x0C) is a 32-bit read/write register. Writing it changes neither enable, route nor either output.
- R10: Writes to offsets 0x00 and 0x10 are ignored. The enable and route registers keep their values.
- R11: Any address other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x20 reads as zero, and writes to such addresses change no register.
- R12: A source whose route bit is 1 never contributes to `irq_o` or offset 0x00. A source whose route bit is 0 never contributes to `fiq_o` or offset 0x10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Raw interrupt source lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, zero when not reading) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A change on `src_i` or a register write takes effect at the next rising edge. From that edge on, the routed views and both outputs reflect it, because they have no register of their own. A read returns data combinationally in the cycle of the request. The bench drives every input on the falling edge and checks read data 1 ns later in that same cycle. At each falling edge it also compares `irq_o` and `fiq_o` with a reference model. That model updates on the rising edge under the same one-edge rule.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned SRC_W_DEF  = 32;
    localparam int unsigned ADDR_W_DEF = 6;

    localparam logic [31:0] OFF_ACT_IRQ = 32'h00;
    localparam logic [31:0] OFF_ENABLE  = 32'h04;
    localparam logic [31:0] OFF_ROUTE   = 32'h08;
    localparam logic [31:0] OFF_CTRL    = 32'h0C;
    localparam logic [31:0] OFF_ACT_FIQ = 32'h10;
    localparam logic [31:0] OFF_RAW     = 32'h20;

    typedef enum logic [2:0] {
        RID_NONE,
        RID_ACT_IRQ,
        RID_ENABLE,
        RID_ROUTE,
        RID_CTRL,
        RID_ACT_FIQ,
        RID_RAW
    } reg_id_e;

    typedef struct packed {
        logic    rd;
        logic    wr;
        reg_id_e id;
    } bus_req_t;

    function automatic reg_id_e decode_addr(input logic [31:0] a);
        reg_id_e r;
        case (a)
            OFF_ACT_IRQ: r = RID_ACT_IRQ;
            OFF_ENABLE:  r = RID_ENABLE;
            OFF_ROUTE:   r = RID_ROUTE;
            OFF_CTRL:    r = RID_CTRL;
            OFF_ACT_FIQ: r = RID_ACT_FIQ;
            OFF_RAW:     r = RID_RAW;
            default:     r = RID_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irqc_sampler.sv
module irqc_sampler #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src_i,
    output logic [W-1:0] raw_q
);

    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= src_i;
    end

    // R2 / R3: raw always follows the sources, whatever the bus does
    a_r2_raw_tracks: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> raw_q == $past(src_i));

endmodule

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs
    import irqc_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_req_t     req,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] enable_q,
    output logic [W-1:0] route_q,
    output logic [W-1:0] ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            route_q  <= '0;
            ctrl_q   <= '0;
        end else if (req.wr) begin
            case (req.id)
                RID_ENABLE: enable_q <= wdata;
                RID_ROUTE:  route_q  <= wdata;
                RID_CTRL:   ctrl_q   <= wdata;
                default:    ;
            endcase
        end
    end

    a_r8_enable_load: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.id == RID_ENABLE) |=> enable_q == $past(wdata));

    a_r8_route_load: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.id == RID_ROUTE) |=> route_q == $past(wdata));

    a_r9_ctrl_isolated: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.id == RID_CTRL) |=> ($stable(enable_q) && $stable(route_q)));

    a_r10_readonly_hold: assert property (@(posedge clk) disable iff (rst)
        (req.wr && (req.id == RID_ACT_IRQ || req.id == RID_ACT_FIQ))
        |=> ($stable(enable_q) && $stable(route_q) && $stable(ctrl_q)));

    a_r11_unmapped_hold: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.id == RID_NONE)
        |=> ($stable(enable_q) && $stable(route_q) && $stable(ctrl_q)));

endmodule

// File: rtl/irqc_steer.sv
module irqc_steer #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] raw,
    input  logic [W-1:0] enable,
    input  logic [W-1:0] route,
    output logic [W-1:0] act_irq,
    output logic [W-1:0] act_fiq,
    output logic         irq_o,
    output logic         fiq_o
);

    for (genvar i = 0; i < W; i++) begin : g_src
        logic live;
        assign live       = raw[i] & enable[i];
        assign act_irq[i] = live & ~route[i];
        assign act_fiq[i] = live &  route[i];
    end

    assign irq_o = |act_irq;
    assign fiq_o = |act_fiq;

endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned SRC_W  = SRC_W_DEF,
    parameter int unsigned ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_W-1:0]  src_i,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SRC_W-1:0]  bus_wdata,
    output logic [SRC_W-1:0]  bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);

    bus_req_t         req;
    logic [SRC_W-1:0] raw_q;
    logic [SRC_W-1:0] enable_q;
    logic [SRC_W-1:0] route_q;
    logic [SRC_W-1:0] ctrl_q;
    logic [SRC_W-1:0] act_irq;
    logic [SRC_W-1:0] act_fiq;

    always_comb begin
        req.rd = bus_sel & ~bus_wr;
        req.wr = bus_sel &  bus_wr;
        req.id = decode_addr(32'(bus_addr));
    end

    irqc_sampler #(.W(SRC_W)) u_sampler (
        .clk   (clk),
        .rst   (rst),
        .src_i (src_i),
        .raw_q (raw_q)
    );

    irqc_cfg_regs #(.W(SRC_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .wdata    (bus_wdata),
        .enable_q (enable_q),
        .route_q  (route_q),
        .ctrl_q   (ctrl_q)
    );

    irqc_steer #(.W(SRC_W)) u_steer (
        .raw     (raw_q),
        .enable  (enable_q),
        .route   (route_q),
        .act_irq (act_irq),
        .act_fiq (act_fiq),
        .irq_o   (irq_o),
        .fiq_o   (fiq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (req.rd) begin
            case (req.id)
                RID_ACT_IRQ: bus_rdata = act_irq;
                RID_ENABLE:  bus_rdata = enable_q;
                RID_ROUTE:   bus_rdata = route_q;
                RID_CTRL:    bus_rdata = ctrl_q;
                RID_ACT_FIQ: bus_rdata = act_fiq;
                RID_RAW:     bus_rdata = raw_q;
                default:     bus_rdata = '0;
            endcase
        end
    end

    // R6 / R12: the normal request needs an enabled source whose route bit is clear
    a_r6_irq_has_source: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (raw_q & enable_q & ~route_q) != '0);

    // R7 / R12: the fast request needs an enabled source whose route bit is set
    a_r7_fiq_has_source: assert property (@(posedge clk) disable iff (rst)
        fiq_o |-> (raw_q & enable_q & route_q) != '0);

    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.id == RID_NONE) |-> bus_rdata == '0);

    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (enable_q == '0 && route_q == '0 && ctrl_q == '0 && !irq_o && !fiq_o));

endmodule

// File: tb/irq_steer_ctrl_test.sv
module irq_steer_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src = '0;
    logic        sel = 1'b0;
    logic        wr  = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    irq_steer_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src),
        .bus_sel   (sel),
        .bus_wr    (wr),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_o     (irq),
        .fiq_o     (fiq)
    );

    // behavioural reference state
    logic [31:0] m_en = '0, m_rt = '0, m_ct = '0, m_raw = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_en <= '0; m_rt <= '0; m_ct <= '0; m_raw <= '0;
        end else begin
            m_raw <= src;
            if (sel && wr) begin
                if (addr == 6'h04) m_en <= wdata;
                if (addr == 6'h08) m_rt <= wdata;
                if (addr == 6'h0C) m_ct <= wdata;
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [5:0] a);
        case (a)
            6'h00:   return m_raw & m_en & ~m_rt;
            6'h04:   return m_en;
            6'h08:   return m_rt;
            6'h0C:   return m_ct;
            6'h10:   return m_raw & m_en & m_rt;
            6'h20:   return m_raw;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // R6 / R7: outputs compared with the model on every falling edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R6 irq_o", {31'b0, irq}, {31'b0, |(m_raw & m_en & ~m_rt)});
            check("R7 fiq_o", {31'b0, fiq}, {31'b0, |(m_raw & m_en & m_rt)});
        end
    end

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    endtask

    task automatic bus_read(input logic [5:0] a, input string tag);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1;
        check(tag, rdata, model_read(a));
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; src = v;
    endtask

    task automatic idle();
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        bus_read(6'h00, "R1 act_irq");
        bus_read(6'h04, "R1 enable");
        bus_read(6'h08, "R1 route");
        bus_read(6'h0C, "R1 ctrl");
        bus_read(6'h10, "R1 act_fiq");
        bus_read(6'h20, "R1 raw");
        check("R1 irq low", {31'b0, irq}, 32'h0);

        // R8: full-width enable and route
        bus_write(6'h04, 32'hFFFF_FFFF);
        bus_read(6'h04, "R8 enable readback");
        bus_write(6'h08, 32'h0000_FFFF);
        bus_read(6'h08, "R8 route readback");

        // R2, R4, R5
        set_src(32'h8000_0001);
        idle();
        bus_read(6'h20, "R2 raw sample");
        bus_read(6'h00, "R4 act_irq");
        bus_read(6'h10, "R5 act_fiq");
        check("R6 irq high", {31'b0, irq}, 32'h1);
        check("R7 fiq high", {31'b0, fiq}, 32'h1);

        // R3: raw ignores writes
        bus_write(6'h20, 32'h0000_1234);
        bus_read(6'h20, "R3 raw unchanged");

        // R10: writes to routed views ignored
        bus_write(6'h00, 32'h0000_0000);
        bus_write(6'h10, 32'h0000_0000);
        bus_read(6'h04, "R10 enable kept");
        bus_read(6'h08, "R10 route kept");
        bus_read(6'h00, "R10 act_irq kept");

        // R9: control register
        bus_write(6'h0C, 32'hA5A5_5A5A);
        bus_read(6'h0C, "R9 ctrl readback");
        bus_read(6'h00, "R9 act_irq unaffected");
        bus_read(6'h10, "R9 act_fiq unaffected");

        // R11: unmapped addresses
        bus_read(6'h14, "R11 unmapped 0x14");
        bus_read(6'h18, "R11 unmapped 0x18");
        bus_read(6'h3C, "R11 unmapped 0x3C");
        bus_read(6'h02, "R11 unmapped 0x02");
        bus_write(6'h24, 32'h0);
        bus_write(6'h05, 32'h0);
        bus_read(6'h04, "R11 enable kept");
        bus_read(6'h08, "R11 route kept");

        // R12: all sources routed fast
        bus_write(6'h08, 32'hFFFF_FFFF);
        set_src(32'h0F0F_0000);
        idle();
        bus_read(6'h00, "R12 act_irq empty");
        check("R12 irq low", {31'b0, irq}, 32'h0);
        check("R12 fiq high", {31'b0, fiq}, 32'h1);
        bus_write(6'h08, 32'h0);
        idle();
        bus_read(6'h10, "R12 act_fiq empty");
        check("R12 fiq low", {31'b0, fiq}, 32'h0);

        // masked: nothing reaches outputs
        bus_write(6'h04, 32'h0);
        idle();
        check("R6 masked irq low", {31'b0, irq}, 32'h0);
        check("R7 masked fiq low", {31'b0, fiq}, 32'h0);

        // mixed patterns
        seed = 32'h1234_5678;
        for (int i = 0; i < 40; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            set_src(seed & {seed[15:0], seed[31:16]});
            seed = seed * 32'd1103515245 + 32'd12345;
            bus_write(6'h04, seed);
            seed = seed * 32'd1103515245 + 32'd12345;
            bus_write(6'h08, seed);
            bus_read(6'h00, "R4 pattern");
            bus_read(6'h10, "R5 pattern");
            bus_read(6'h20, "R2 pattern");
        end

        // R1: reset mid-run
        @(negedge clk);
        sel = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        bus_read(6'h04, "R1 enable after reset");
        bus_read(6'h08, "R1 route after reset");
        bus_read(6'h0C, "R1 ctrl after reset");
        idle();
        idle();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule